// File: doc/BRIEF.md
# Adaptive Delta Modulation Decoder

This block turns a one-bit adaptive delta modulation stream back into 8-bit two's-complement PCM samples. It keeps a signed step size, a reconstructed sample and a short history of the last two received bits. On every cycle where the sample strobe is high, it does four things in order:

- It adapts the step from that history.
- It adds the step to the sample.
- It publishes the new sample.
- It shifts the incoming bit into the history.

The adaptation rule matches the one used by the paired encoder. A decoder driven by that encoder's bit stream therefore rebuilds exactly the encoder's own prediction, sample for sample.

The current input bit never influences the sample produced on the same strobe. It only steers the step from the following strobe onward. Arithmetic wraps silently, with no saturation.

Top module: `adm_decoder`

## Requirements
- R1: After a cycle with `rst` high, `pcm_out` is 0. The step and the bit history are also cleared, so a fresh run starts from a zero step and a history of two zero bits.
- R2: On a cycle with `sample_en` low, `pcm_out` and all internal state keep their values, whatever `adm_bit` does.
- R3: On a strobe, the working step is first the magnitude of the stored step. It is then negated when the newest history bit (the bit received on the previous strobe) is 0.
- R4: The working step is then incremented by one when the older history bit (the bit received two strobes back) is 1, and decremented by one otherwise. The result becomes the stored step, with no overflow check.
- R5: On a strobe, the new sample equals the previous sample plus the new step, wrapping modulo 256. The new sample appears on `pcm_out` after that clock edge.
- R6: The bit on `adm_bit` during a strobe is shifted into the history after the sample update. It therefore has no effect on the `pcm_out` value produced by that same strobe.
- R7: From reset, with `adm_bit` held at 1, the first eight outputs are -1, -1, 0, 2, 5, 9, 14, 20.
- R8: When fed the bit stream of an encoder that uses the same adaptation rule, and emits 1 when its input exceeds its updated prediction, `pcm_out` equals the encoder's prediction after every strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle strobe per received bit |
| adm_bit | input | 1 | Received delta modulation bit, valid while `sample_en` is high |
| pcm_out | output | 8 | Reconstructed signed sample, registered |

## Verification
The embedded assertions check the following on every cycle:

- Idle cycles leave the output stable.
- The history register shifts correctly.
- Each new sample is the old sample plus the stored step.
- The step grows by one when the history shows two ones and shrinks by one when it shows two zeros, away from the signed limits.

Other behaviours can only be shown by the bench's scenarios. These are the exact reset-start sequence, the one-strobe delay before a bit takes effect, wraparound over long runs of equal bits, and lockstep tracking of an encoder driven by a shaped waveform.

// File: rtl/adm_pkg.sv
package adm_pkg;

    localparam int unsigned PCM_W  = 8;
    localparam int unsigned HIST_W = 2;

    // Direction of the unit adjustment applied to the working step
    typedef enum logic {
        ADJ_DOWN = 1'b0,
        ADJ_UP   = 1'b1
    } step_adj_e;

    // The two history bits that steer adaptation
    typedef struct packed {
        logic older;   // bit received two strobes ago
        logic newer;   // bit received on the previous strobe
    } hist_taps_t;

    function automatic step_adj_e adj_from_taps(input hist_taps_t t);
        return t.older ? ADJ_UP : ADJ_DOWN;
    endfunction

endpackage

// File: rtl/adm_history.sv
module adm_history #(
    parameter int unsigned HIST_W = adm_pkg::HIST_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               bit_in,
    output adm_pkg::hist_taps_t taps
);
    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (en) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

    assign taps.newer = hist_q[0];
    assign taps.older = hist_q[1];

    // R6
    hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (hist_q[0] == $past(bit_in)) && (hist_q[1] == $past(hist_q[0])));

endmodule

// File: rtl/adm_step_adapt.sv
module adm_step_adapt #(
    parameter int unsigned DATA_W = adm_pkg::PCM_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  adm_pkg::hist_taps_t       taps,
    output logic signed [DATA_W-1:0]  step_nxt,
    output logic signed [DATA_W-1:0]  step_q
);
    import adm_pkg::*;

    localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] ONE   = DATA_W'(1);

    logic signed [DATA_W-1:0] mag;
    logic signed [DATA_W-1:0] oriented;
    step_adj_e                adj;

    always_comb begin
        mag      = step_q[DATA_W-1] ? (-step_q) : step_q;
        oriented = taps.newer ? mag : (-mag);
        adj      = adj_from_taps(taps);
        step_nxt = (adj == ADJ_UP) ? (oriented + ONE) : (oriented - ONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (en) begin
            step_q <= step_nxt;
        end
    end

    // R4
    step_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && taps.older && taps.newer && !step_q[DATA_W-1] && step_q != S_MAX)
        |=> step_q == $past(step_q) + ONE);

    // R3
    step_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !taps.older && !taps.newer && (step_q[DATA_W-1] || step_q == '0)
            && step_q != S_MIN)
        |=> step_q == $past(step_q) - ONE);

endmodule

// File: rtl/adm_accum.sv
module adm_accum #(
    parameter int unsigned DATA_W = adm_pkg::PCM_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] step_in,
    output logic signed [DATA_W-1:0] sample_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q <= '0;
        end else if (en) begin
            sample_q <= sample_q + step_in;
        end
    end
endmodule

// File: rtl/adm_decoder.sv
module adm_decoder #(
    parameter int unsigned DATA_W = adm_pkg::PCM_W,
    parameter int unsigned HIST_W = adm_pkg::HIST_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_en,
    input  logic                     adm_bit,
    output logic signed [DATA_W-1:0] pcm_out
);
    import adm_pkg::*;

    hist_taps_t               taps;
    logic signed [DATA_W-1:0] step_nxt;
    logic signed [DATA_W-1:0] step_q;

    adm_history #(.HIST_W(HIST_W)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .en     (sample_en),
        .bit_in (adm_bit),
        .taps   (taps)
    );

    adm_step_adapt #(.DATA_W(DATA_W)) u_step (
        .clk      (clk),
        .rst      (rst),
        .en       (sample_en),
        .taps     (taps),
        .step_nxt (step_nxt),
        .step_q   (step_q)
    );

    adm_accum #(.DATA_W(DATA_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .en       (sample_en),
        .step_in  (step_nxt),
        .sample_q (pcm_out)
    );

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(pcm_out) && $stable(step_q) && $stable(taps));

    // R5
    accum_sum_chk: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> pcm_out == DATA_W'($past(pcm_out) + step_q));

endmodule

// File: tb/adm_decoder_bench.sv
module adm_decoder_bench;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_en = 1'b0;
    logic adm_bit = 1'b0;
    logic signed [7:0] pcm_out;

    int n_checks = 0;
    int n_fail = 0;

    typedef struct {
        logic signed [7:0] val;
        string tag;
    } exp_t;
    exp_t sb[$];

    // reference state
    logic signed [7:0] r_step, r_x;
    logic [1:0] r_hist;
    // encoder state
    logic signed [7:0] e_step, e_x;
    logic [1:0] e_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    adm_decoder u_adm_decoder (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .adm_bit(adm_bit), .pcm_out(pcm_out)
    );

    task automatic check(input logic signed [7:0] act, input logic signed [7:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic adapt(inout logic signed [7:0] s, inout logic signed [7:0] x, input logic [1:0] h);
        logic signed [7:0] m;
        m = s[7] ? -s : s;
        if (!h[0]) m = -m;
        s = h[1] ? m + 8'sd1 : m - 8'sd1;
        x = x + s;
    endtask

    // reference model step: returns expected output for this strobe
    task automatic ref_step(input logic b, output logic signed [7:0] y);
        adapt(r_step, r_x, r_hist);
        y = r_x;
        r_hist = {r_hist[0], b};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; sample_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        r_step = 0; r_x = 0; r_hist = 0;
        e_step = 0; e_x = 0; e_hist = 0;
    endtask

    // driver: push expected item, drive one strobe
    task automatic send(input logic b, input string tag, input logic use_fixed = 0,
                        input logic signed [7:0] fixed = 0);
        exp_t it;
        logic signed [7:0] y;
        ref_step(b, y);
        it.val = use_fixed ? fixed : y;
        it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        adm_bit = b; sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    // monitor
    always @(posedge clk) begin
        if (sample_en && !rst) begin
            #1;
            if (sb.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R5: actual %0d expected none (unexpected strobe)", pcm_out);
            end else begin
                exp_t it;
                it = sb.pop_front();
                check(pcm_out, it.val, it.tag);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic signed [7:0] seq [8] = '{-8'sd1, -8'sd1, 8'sd0, 8'sd2, 8'sd5, 8'sd9, 8'sd14, 8'sd20};
        logic signed [7:0] held;

        // R1: reset state
        do_reset();
        #1 check(pcm_out, 0, "R1");

        // R7: constant-one sequence from reset
        for (int i = 0; i < 8; i++) send(1'b1, "R7", 1'b1, seq[i]);

        // R2: idle cycles with toggling bit
        @(negedge clk);
        held = pcm_out;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); adm_bit = ~adm_bit;
        end
        check(pcm_out, held, "R2");
        // state untouched: next strobe continues sequence (step 7 -> 27)
        send(1'b1, "R2", 1'b1, 8'sd27);

        // R5: long run of ones wraps the sample
        for (int i = 0; i < 40; i++) send(1'b1, "R5");

        // R1: reset mid-run clears everything; R6: first bit 0 still gives -1
        do_reset();
        #1 check(pcm_out, 0, "R1");
        send(1'b0, "R6", 1'b1, -8'sd1);
        // second strobe: history {0,0} -> step -1-1 = -2, sample -3
        send(1'b1, "R6", 1'b1, -8'sd3);
        // now newest bit 1: step |−2|=2, older 0 -> 1, sample -2
        send(1'b0, "R3", 1'b1, -8'sd2);

        // R3/R4: alternating and run of zeros
        for (int i = 0; i < 12; i++) send(logic'(i[0]), "R4");
        for (int i = 0; i < 10; i++) send(1'b0, "R3");
        for (int i = 0; i < 200; i++) send(logic'($urandom_range(0, 1)), "R4");

        // R8: encoder in lockstep with a shaped target
        do_reset();
        for (int k = 0; k < 300; k++) begin
            int tgt;
            logic eb;
            tgt = (k % 100 < 50) ? (k % 100) * 2 - 50 : 150 - (k % 100) * 2;
            adapt(e_step, e_x, e_hist);
            eb = (tgt > int'(e_x));
            e_hist = {e_hist[0], eb};
            send(eb, "R8", 1'b1, e_x);
        end

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            n_checks++; n_fail++;
            $display("FAIL R5: actual %0d pending expected 0", sb.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule